// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block chooses the power-managed state of a small microcontroller. When the core raises a one-cycle sleep request, the block samples two control bits, idle-enable and deep-sleep-enable, in that same cycle. It also reads the two-bit clock-source select field. From these values it picks an idle, sleep or deep-sleep state. The state drives a CPU clock enable, a peripheral clock enable and a regulator shutdown request. A sleep request made while the block is already in a low-power state samples the bits again, so the device can move directly between idle, sleep and deep sleep.

A one-bit wake input ends a low-power state. From idle or sleep, the block goes back to the run state that matches the select field. From deep sleep, it first runs a restart sequence of fixed length, with both clocks gated. After that sequence it resumes in the start-up run state. The start-up run state is primary run. It becomes internal-RC run when the fast-start strap is high during reset. The current state is output as a 3-bit code.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is high and after it is released, the mode code is 0 (primary run) with both clock enables high, or 2 (internal-RC run) if fast_start was high during reset.
- R2: In a run state (codes 0, 1, 2), both clock enables are 1 and vreg_off_req is 0. Each cycle, the next code follows clk_sel: 00 gives 0, 01 gives 1, 10 or 11 gives 2.
- R3: A sleep request with deep_en=1 gives code 7 (deep sleep). In that state both clock enables are 0 and vreg_off_req is 1.
- R4: A sleep request with deep_en=0 and idle_en=0 gives code 6 (sleep). In that state both clock enables are 0 and vreg_off_req is 0.
- R5: A sleep request with deep_en=0 and idle_en=1 gives an idle code chosen by clk_sel in the request cycle: 00 gives 3, 01 gives 4, 10 or 11 gives 5. In idle, cpu_clk_en is 0 and per_clk_en is 1.
- R6: idle_en and deep_en have no effect in any cycle without a sleep request.
- R7: A sleep request made in a low-power state (codes 3 to 7) samples the bits again and moves to the state they now select.
- R8: A wake in idle or sleep gives, one cycle later, the run code that matches the current clk_sel.
- R9: A wake in deep sleep raises sys_rst_req for exactly RST_CYCLES cycles. During that time both clock enables are 0, vreg_off_req is 0 and the code is the start-up run code. Afterwards the code follows clk_sel again.
- R10: A sleep request in the same cycle as a wake is ignored, and the wake (or, in a run state, normal select tracking) takes effect.
- R11: While sys_rst_req is high, sleep requests and clk_sel changes are ignored and the mode code stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_start | input | 1 | Start-up strap; selects internal-RC run as the start state |
| sleep_req | input | 1 | Sleep request pulse from the core |
| idle_en | input | 1 | Idle-enable control bit |
| deep_en | input | 1 | Deep-sleep-enable control bit |
| clk_sel | input | 2 | Clock-source select field |
| wake | input | 1 | Wake event |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| vreg_off_req | output | 1 | Regulator shutdown request |
| sys_rst_req | output | 1 | Restart sequence active after a deep-sleep wake |
| mode_code | output | 3 | Current mode code |

## Verification
Every output is decoded from the registered mode and the restart counter. A wrong internal state therefore shows up at the ports in the first cycle after the faulty clock edge. It appears as a wrong mode code, as clock enables that disagree with the code, or as a restart pulse of the wrong length. A reference model compares all five outputs every cycle, so a stale sample of the control bits, a lost wake priority, or an off-by-one in the restart count fails within one cycle of the stimulus that exposes it.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        M_PRI_RUN  = 3'd0,
        M_SEC_RUN  = 3'd1,
        M_RC_RUN   = 3'd2,
        M_PRI_IDLE = 3'd3,
        M_SEC_IDLE = 3'd4,
        M_RC_IDLE  = 3'd5,
        M_SLEEP    = 3'd6,
        M_DEEP     = 3'd7
    } pm_mode_e;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic vreg_off;
    } clk_ctl_t;

    function automatic pm_mode_e run_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return M_PRI_RUN;
            2'b01:   return M_SEC_RUN;
            default: return M_RC_RUN;
        endcase
    endfunction

    function automatic pm_mode_e idle_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return M_PRI_IDLE;
            2'b01:   return M_SEC_IDLE;
            default: return M_RC_IDLE;
        endcase
    endfunction

    function automatic logic is_run(input pm_mode_e m);
        return (m == M_PRI_RUN) || (m == M_SEC_RUN) || (m == M_RC_RUN);
    endfunction

    function automatic logic is_idle(input pm_mode_e m);
        return (m == M_PRI_IDLE) || (m == M_SEC_IDLE) || (m == M_RC_IDLE);
    endfunction

    function automatic pm_mode_e target_of(input logic idle, input logic deep,
                                           input logic [1:0] sel);
        if (deep)
            return M_DEEP;
        else if (idle)
            return idle_of(sel);
        else
            return M_SLEEP;
    endfunction

endpackage

// File: rtl/pms_next_mode.sv
module pms_next_mode
    import pwr_mode_pkg::*;
(
    input  pm_mode_e   cur_mode,
    input  pm_mode_e   start_mode,
    input  logic       busy,
    input  logic       sleep_req,
    input  logic       wake,
    input  logic       idle_en,
    input  logic       deep_en,
    input  logic [1:0] clk_sel,
    output pm_mode_e   nxt_mode,
    output logic       load_restart
);
    always_comb begin
        nxt_mode     = cur_mode;
        load_restart = 1'b0;
        if (busy) begin
            nxt_mode = cur_mode;
        end else if (wake && !is_run(cur_mode)) begin
            if (cur_mode == M_DEEP) begin
                nxt_mode     = start_mode;
                load_restart = 1'b1;
            end else begin
                nxt_mode = run_of(clk_sel);
            end
        end else if (sleep_req && !wake) begin
            nxt_mode = target_of(idle_en, deep_en, clk_sel);
        end else if (is_run(cur_mode)) begin
            nxt_mode = run_of(clk_sel);
        end
    end
endmodule

// File: rtl/pms_restart_timer.sv
module pms_restart_timer #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    generate
        if (RST_CYCLES == 0) begin : g_none
            assign busy = 1'b0;
        end else begin : g_count
            localparam int CNT_W = $clog2(RST_CYCLES + 1);
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q <= '0;
                else if (load)
                    cnt_q <= CNT_W'(RST_CYCLES);
                else if (cnt_q != '0)
                    cnt_q <= cnt_q - 1'b1;
            end
            assign busy = (cnt_q != '0);
        end
    endgenerate
endmodule

// File: rtl/pms_clk_ctl.sv
module pms_clk_ctl
    import pwr_mode_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     busy,
    output clk_ctl_t ctl
);
    always_comb begin
        ctl.cpu_en   = is_run(mode) && !busy;
        ctl.per_en   = (is_run(mode) && !busy) || is_idle(mode);
        ctl.vreg_off = (mode == M_DEEP);
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fast_start,
    input  logic       sleep_req,
    input  logic       idle_en,
    input  logic       deep_en,
    input  logic [1:0] clk_sel,
    input  logic       wake,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       vreg_off_req,
    output logic       sys_rst_req,
    output logic [2:0] mode_code
);
    pm_mode_e mode_q, mode_d, start_mode;
    logic     fast_q, busy, load_restart;
    clk_ctl_t ctl;

    assign start_mode = fast_q ? M_RC_RUN : M_PRI_RUN;

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_q <= fast_start;
            mode_q <= fast_start ? M_RC_RUN : M_PRI_RUN;
        end else begin
            mode_q <= mode_d;
        end
    end

    pms_next_mode i_next (
        .cur_mode    (mode_q),
        .start_mode  (start_mode),
        .busy        (busy),
        .sleep_req   (sleep_req),
        .wake        (wake),
        .idle_en     (idle_en),
        .deep_en     (deep_en),
        .clk_sel     (clk_sel),
        .nxt_mode    (mode_d),
        .load_restart(load_restart)
    );

    pms_restart_timer #(.RST_CYCLES(RST_CYCLES)) i_timer (
        .clk (clk),
        .rst (rst),
        .load(load_restart),
        .busy(busy)
    );

    pms_clk_ctl i_ctl (
        .mode(mode_q),
        .busy(busy),
        .ctl (ctl)
    );

    assign cpu_clk_en   = ctl.cpu_en;
    assign per_clk_en   = ctl.per_en;
    assign vreg_off_req = ctl.vreg_off;
    assign sys_rst_req  = busy;
    assign mode_code    = mode_q;
endmodule

// File: rtl/pms_checker.sv
module pms_checker (
    input logic       clk,
    input logic       rst,
    input logic       sleep_req,
    input logic       wake,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       vreg_off_req,
    input logic       sys_rst_req,
    input logic [2:0] mode_code
);
    a_r3_deep_gates_all: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd7) |-> (vreg_off_req && !cpu_clk_en && !per_clk_en));

    a_r4_sleep_gates_clocks: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd6) |-> (!vreg_off_req && !cpu_clk_en && !per_clk_en));

    a_r5_idle_keeps_periph: assert property (@(posedge clk) disable iff (rst)
        (mode_code >= 3'd3 && mode_code <= 3'd5) |-> (!cpu_clk_en && per_clk_en));

    a_r2_run_clocks_on: assert property (@(posedge clk) disable iff (rst)
        (mode_code <= 3'd2 && !sys_rst_req) |-> (cpu_clk_en && per_clk_en && !vreg_off_req));

    a_r8_wake_exits: assert property (@(posedge clk) disable iff (rst)
        (wake && mode_code >= 3'd3 && !sys_rst_req) |=> (mode_code <= 3'd2));

    a_r10_wake_beats_sleep: assert property (@(posedge clk) disable iff (rst)
        (wake && sleep_req && !sys_rst_req) |=> (mode_code <= 3'd2));

    a_r9_restart_from_deep: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_req) |-> ($past(mode_code) == 3'd7 && $past(wake)));

    a_r11_restart_holds_mode: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_req && $past(sys_rst_req)) |-> $stable(mode_code));
endmodule

bind pwr_mode_seq pms_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .sleep_req   (sleep_req),
    .wake        (wake),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .vreg_off_req(vreg_off_req),
    .sys_rst_req (sys_rst_req),
    .mode_code   (mode_code)
);

// File: tb/test_pwr_mode_seq.sv
`timescale 1ns/1ps
module test_pwr_mode_seq;
    localparam int RSTC = 4;

    logic       clk = 1'b0;
    logic       rst, fast_start, sleep_req, idle_en, deep_en, wake;
    logic [1:0] clk_sel;
    logic       cpu_clk_en, per_clk_en, vreg_off_req, sys_rst_req;
    logic [2:0] mode_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_tag = "R1";

    int m_mode = 0;
    int m_cnt = 0;
    int m_fast = 0;

    always #2.5 clk = ~clk;

    pwr_mode_seq #(.RST_CYCLES(RSTC)) i_pwr_mode_seq (
        .clk(clk), .rst(rst), .fast_start(fast_start), .sleep_req(sleep_req),
        .idle_en(idle_en), .deep_en(deep_en), .clk_sel(clk_sel), .wake(wake),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .vreg_off_req(vreg_off_req), .sys_rst_req(sys_rst_req),
        .mode_code(mode_code)
    );

    function automatic int sel_idx(input logic [1:0] s);
        return (s == 2'b00) ? 0 : (s == 2'b01) ? 1 : 2;
    endfunction

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_fast = fast_start ? 1 : 0;
            m_mode = m_fast ? 2 : 0;
            m_cnt  = 0;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
        end else if (wake && m_mode >= 3) begin
            if (m_mode == 7) begin
                m_mode = m_fast ? 2 : 0;
                m_cnt  = RSTC;
            end else begin
                m_mode = sel_idx(clk_sel);
            end
        end else if (sleep_req && !wake) begin
            if (deep_en) m_mode = 7;
            else if (idle_en) m_mode = 3 + sel_idx(clk_sel);
            else m_mode = 6;
        end else if (m_mode < 3) begin
            m_mode = sel_idx(clk_sel);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always begin
        @(negedge clk);
        #1;
        if (!rst) begin
            int e_cpu, e_per, e_vreg, e_rst;
            e_rst  = (m_cnt != 0);
            e_cpu  = (m_mode < 3 && m_cnt == 0);
            e_per  = e_cpu || (m_mode >= 3 && m_mode <= 5);
            e_vreg = (m_mode == 7);
            checks++;
            if (mode_code != m_mode || cpu_clk_en != e_cpu || per_clk_en != e_per ||
                vreg_off_req != e_vreg || sys_rst_req != e_rst) begin
                failures++;
                $display("FAIL %s model actual=%0d/%b%b%b%b expected=%0d/%0d%0d%0d%0d",
                         cur_tag, mode_code, cpu_clk_en, per_clk_en, vreg_off_req,
                         sys_rst_req, m_mode, e_cpu, e_per, e_vreg, e_rst);
            end
        end
    end

    task automatic cyc(input logic r, input logic i, input logic d,
                       input logic [1:0] s, input logic w);
        sleep_req = r; idle_en = i; deep_en = d; clk_sel = s; wake = w;
        @(negedge clk);
        #2;
    endtask

    task automatic chk_out(input string tag, input int md, input int c, input int p,
                           input int v, input int sr);
        chk({tag, " mode"}, mode_code, md);
        chk({tag, " cpu"}, cpu_clk_en, c);
        chk({tag, " per"}, per_clk_en, p);
        chk({tag, " vreg"}, vreg_off_req, v);
        chk({tag, " rstreq"}, sys_rst_req, sr);
    endtask

    initial begin
        rst = 1; fast_start = 0;
        cur_tag = "R1";
        cyc(0, 0, 0, 2'b00, 0);
        cyc(0, 0, 0, 2'b00, 0);
        chk_out("R1 reset primary", 0, 1, 1, 0, 0);
        rst = 0;
        cyc(0, 0, 0, 2'b00, 0);
        chk_out("R1 after release", 0, 1, 1, 0, 0);

        cur_tag = "R2";
        cyc(0, 0, 0, 2'b01, 0); chk_out("R2 sel01", 1, 1, 1, 0, 0);
        cyc(0, 0, 0, 2'b11, 0); chk_out("R2 sel11", 2, 1, 1, 0, 0);
        cyc(0, 0, 0, 2'b10, 0); chk_out("R2 sel10", 2, 1, 1, 0, 0);
        cyc(0, 0, 0, 2'b00, 0); chk_out("R2 sel00", 0, 1, 1, 0, 0);

        cur_tag = "R5";
        cyc(1, 1, 0, 2'b01, 0); chk_out("R5 idle sec", 4, 0, 1, 0, 0);
        cur_tag = "R6";
        cyc(0, 0, 1, 2'b00, 0); chk_out("R6 bits ignored", 4, 0, 1, 0, 0);
        cyc(0, 0, 0, 2'b11, 0); chk_out("R6 bits ignored again", 4, 0, 1, 0, 0);

        cur_tag = "R7";
        cyc(1, 1, 0, 2'b10, 0); chk_out("R7 idle to rc idle", 5, 0, 1, 0, 0);
        cyc(1, 0, 1, 2'b00, 0); chk_out("R3 R7 to deep", 7, 0, 0, 1, 0);
        cyc(1, 0, 0, 2'b00, 0); chk_out("R4 R7 deep to sleep", 6, 0, 0, 0, 0);

        cur_tag = "R8";
        cyc(0, 0, 0, 2'b11, 1); chk_out("R8 wake from sleep", 2, 1, 1, 0, 0);
        cyc(1, 1, 0, 2'b00, 0); chk_out("R5 idle pri", 3, 0, 1, 0, 0);
        cyc(0, 0, 0, 2'b01, 1); chk_out("R8 wake from idle", 1, 1, 1, 0, 0);

        cur_tag = "R10";
        cyc(1, 0, 0, 2'b00, 1); chk_out("R10 run sleep+wake", 0, 1, 1, 0, 0);
        cyc(1, 1, 0, 2'b00, 0); chk_out("R10 setup idle", 3, 0, 1, 0, 0);
        cyc(1, 0, 1, 2'b01, 1); chk_out("R10 idle sleep+wake", 1, 1, 1, 0, 0);

        cur_tag = "R9";
        cyc(1, 0, 1, 2'b01, 0); chk_out("R3 deep", 7, 0, 0, 1, 0);
        cyc(0, 0, 0, 2'b01, 1); chk_out("R9 restart start", 0, 0, 0, 0, 1);
        cur_tag = "R11";
        for (int k = 0; k < RSTC - 1; k++) begin
            cyc(1, 0, 1, 2'b11, 0);
            chk_out("R11 restart holds", 0, 0, 0, 0, 1);
        end
        cur_tag = "R9";
        cyc(0, 0, 0, 2'b01, 0); chk_out("R9 restart done", 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 2'b01, 0); chk_out("R9 tracks select", 1, 1, 1, 0, 0);

        cur_tag = "R1";
        rst = 1; fast_start = 1;
        cyc(0, 0, 0, 2'b11, 0);
        cyc(0, 0, 0, 2'b11, 0);
        chk_out("R1 reset fast start", 2, 1, 1, 0, 0);
        rst = 0; fast_start = 0;
        cyc(1, 0, 1, 2'b11, 0); chk_out("R3 deep from rc", 7, 0, 0, 1, 0);
        cyc(0, 0, 0, 2'b00, 1); chk_out("R9 fast restart", 2, 0, 0, 0, 1);

        cur_tag = "R7 random";
        for (int n = 0; n < 3000; n++) begin
            int rr;
            rr = $urandom_range(0, 99);
            cyc(rr < 12, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                2'($urandom_range(0, 3)), $urandom_range(0, 99) < 10);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule